// File: doc/BRIEF.md
# Horizontal Two-Band Synthesis Filter

This block carries out one horizontal reconstruction step of a separable two-band wavelet synthesis. Coefficients of a line arrive one per beat, with the four band kinds interleaved (LL, LH, HL, HH, then LL again for the next index). For each band the block keeps the current and the previous coefficient. With the pair (X[i], X[i+1]) of a band it evaluates the upsampled 4-tap kernel directly. The even phase needs only two taps and so does the odd phase, so no zeros are ever inserted and no multiplier is used. The low-pass band of each pair (LL or HL) goes through the low-pass kernel. The high-pass band (LH or HH) goes through the same shift-add arithmetic with its two inputs exchanged and the even result negated. The two results are added to give either an L sample pair (from LL and LH) or an H sample pair (from HL and HH).

The block keeps the first coefficient of every band on each line. For the last index of a line the filter needs one coefficient past the end, and this saved first value wraps in as that coefficient. Producing these two wrap-around results takes two extra output beats, during which input is held off. Every sum is rounded half up, scaled down to the input precision and clamped. The output is a valid/ready stream of even/odd pairs tagged L or H.

Top module: `subband_hsynth`

## Requirements
- R1: For a low-pass band pair (a = X[i], b = X[i+1]) the contribution is even = 6a − b and odd = 3a + 2b. LL is the low-pass band of an L result and HL the low-pass band of an H result.
- R2: For a high-pass band pair (c = X[i], d = X[i+1]) the contribution is even = c − 6d and odd = 2c + 3d. LH is the high-pass band of an L result and HH the high-pass band of an H result.
- R3: The input tag is coded LL=0, LH=1, HL=2, HH=3, and the beats must come in that cyclic order. The output tag is coded L=0 and H=1. For each index the L pair is emitted first and the H pair second.
- R4: The first group of four beats on a line (the group whose LL beat has the line-start flag) produces no output. Each later group produces one L pair and one H pair, for index i−1.
- R5: After the HH beat of the group whose LL beat has the line-end flag, the block emits the L pair and then the H pair for the last index. These use the saved first coefficients of the line as X[i+1]. in_ready stays low while these two results are pending.
- R6: Each combined sum s becomes floor((s + 4) / 8), which is rounding half up with a 3-bit scale-down.
- R7: A rounded value above 511 is output as 511, and one below −512 is output as −512.
- R8: While out_valid is high and out_ready is low, out_valid, out_tag, out_even and out_odd hold their values. No result is lost or duplicated.
- R9: During and right after reset, out_valid is low and in_ready is high.
- R10: A line of a single group (both flags set on its LL beat) yields exactly one L pair and one H pair, each computed with X[i+1] = X[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block takes the input beat |
| in_tag | input | 2 | Band kind of the beat (LL=0, LH=1, HL=2, HH=3) |
| in_line_start | input | 1 | On an LL beat: group is the first of its line |
| in_line_end | input | 1 | On an LL beat: group is the last of its line |
| in_data | input | 10 | Signed coefficient |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_tag | output | 1 | 0 = L pair, 1 = H pair |
| out_even | output | 10 | Signed even-phase sample |
| out_odd | output | 10 | Signed odd-phase sample |

## Verification
The assertions assume that the upstream source sends band tags strictly in the LL, LH, HL, HH order. They also assume that the line flags are meaningful only on LL beats, and the band-order property checks that the source honours this. The bench drives whole lines only, and it sets both flags on the LL beat of the matching group and clears them on every other beat, so the assumption always holds. The assertions about backpressure and the wrap-around bubble take no stimulus for granted beyond this ordering, and the bench varies the downstream ready pattern from always-on to mostly-stalled.

// File: rtl/subband_hsynth_pkg.sv
package subband_hsynth_pkg;
  typedef enum logic [1:0] {
    BAND_LL = 2'd0,
    BAND_LH = 2'd1,
    BAND_HL = 2'd2,
    BAND_HH = 2'd3
  } band_e;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_WRAP_L = 2'd1,
    PH_WRAP_H = 2'd2
  } phase_e;

  localparam int NUM_BANDS = 4;
endpackage

// File: rtl/subband_band_store.sv
module subband_band_store #(
  parameter int DATA_W = 10,
  parameter int NBANDS = 4,
  localparam int SEL_W = $clog2(NBANDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_band,
  input  logic                     wr_first,
  input  logic signed [DATA_W-1:0] wr_data,
  output logic [NBANDS-1:0][DATA_W-1:0] cur_q,
  output logic [NBANDS-1:0][DATA_W-1:0] prv_q,
  output logic [NBANDS-1:0][DATA_W-1:0] first_q
);
  // one register set per band kind: newest, previous, first on the line
  for (genvar g = 0; g < NBANDS; g++) begin : g_band
    logic hit;
    assign hit = wr_en && (wr_band == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[g]   <= '0;
        prv_q[g]   <= '0;
        first_q[g] <= '0;
      end else if (hit) begin
        prv_q[g] <= cur_q[g];
        cur_q[g] <= wr_data;
        if (wr_first) first_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/subband_tap_kernel.sv
module subband_tap_kernel #(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 14,
  parameter bit HIGH   = 1'b0
) (
  input  logic signed [DATA_W-1:0] x_near,
  input  logic signed [DATA_W-1:0] x_far,
  output logic signed [ACC_W-1:0]  y_even,
  output logic signed [ACC_W-1:0]  y_odd
);
  // even phase: 6p - q, built from two shifts
  function automatic logic signed [ACC_W-1:0] phase_even(
    input logic signed [ACC_W-1:0] p, input logic signed [ACC_W-1:0] q);
    return (p <<< 2) + (p <<< 1) - q;
  endfunction

  // odd phase: 3p + 2q
  function automatic logic signed [ACC_W-1:0] phase_odd(
    input logic signed [ACC_W-1:0] p, input logic signed [ACC_W-1:0] q);
    return (p <<< 1) + p + (q <<< 1);
  endfunction

  logic signed [ACC_W-1:0] ext_near, ext_far;
  assign ext_near = ACC_W'(x_near);
  assign ext_far  = ACC_W'(x_far);

  if (HIGH) begin : g_high
    // reversed taps: operands exchanged, (6,-1) pair negated
    assign y_even = -phase_even(ext_far, ext_near);
    assign y_odd  = phase_odd(ext_far, ext_near);
  end else begin : g_low
    assign y_even = phase_even(ext_near, ext_far);
    assign y_odd  = phase_odd(ext_near, ext_far);
  end
endmodule

// File: rtl/subband_round_sat.sv
module subband_round_sat #(
  parameter int ACC_W  = 14,
  parameter int DATA_W = 10,
  parameter int SHIFT  = 3
) (
  input  logic signed [ACC_W-1:0]  sum_in,
  output logic signed [DATA_W-1:0] val_out
);
  localparam int WIDE_W = ACC_W + 1;
  localparam logic signed [WIDE_W-1:0] HALF  = WIDE_W'(1) <<< (SHIFT - 1);
  localparam logic signed [WIDE_W-1:0] V_MAX = WIDE_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] V_MIN = -(WIDE_W'(1) <<< (DATA_W - 1));

  function automatic logic signed [DATA_W-1:0] round_clamp(
    input logic signed [ACC_W-1:0] s);
    logic signed [WIDE_W-1:0] biased, scaled;
    biased = WIDE_W'(s) + HALF;
    scaled = biased >>> SHIFT;
    if (scaled > V_MAX)      return V_MAX[DATA_W-1:0];
    else if (scaled < V_MIN) return V_MIN[DATA_W-1:0];
    else                     return scaled[DATA_W-1:0];
  endfunction

  assign val_out = round_clamp(sum_in);
endmodule

// File: rtl/subband_hsynth.sv
module subband_hsynth
  import subband_hsynth_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int GUARD  = 4,
  parameter int SHIFT  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               in_tag,
  input  logic                     in_line_start,
  input  logic                     in_line_end,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_tag,
  output logic signed [DATA_W-1:0] out_even,
  output logic signed [DATA_W-1:0] out_odd
);
  localparam int ACC_W = DATA_W + GUARD;

  // ---------------- control state ----------------
  phase_e phase_q;
  logic   grp_first_q, grp_last_q;
  logic   out_valid_q;

  logic out_free, accept, cur_first, cur_last;
  logic emit_run, emit_wrap, emit, emit_seg;
  logic wrap_busy, line_done;

  assign out_free  = !out_valid_q || out_ready;
  assign wrap_busy = (phase_q != PH_RUN);
  assign in_ready  = !wrap_busy && out_free;
  assign accept    = in_valid && in_ready;

  // line flags are carried by the LL beat and apply to its whole group
  assign cur_first = (in_tag == BAND_LL) ? in_line_start : grp_first_q;
  assign cur_last  = (in_tag == BAND_LL) ? in_line_end   : grp_last_q;

  assign emit_run  = accept && in_tag[0] && !cur_first;
  assign emit_wrap = wrap_busy && out_free;
  assign emit      = emit_run || emit_wrap;
  assign emit_seg  = wrap_busy ? (phase_q == PH_WRAP_H) : in_tag[1];
  assign line_done = accept && (in_tag == BAND_HH) && cur_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_first_q <= 1'b0;
      grp_last_q  <= 1'b0;
    end else if (accept && in_tag == BAND_LL) begin
      grp_first_q <= in_line_start;
      grp_last_q  <= in_line_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
    end else begin
      unique case (phase_q)
        PH_RUN:    if (line_done) phase_q <= PH_WRAP_L;
        PH_WRAP_L: if (out_free)  phase_q <= PH_WRAP_H;
        PH_WRAP_H: if (out_free)  phase_q <= PH_RUN;
        default:   phase_q <= PH_RUN;
      endcase
    end
  end

  // ---------------- coefficient storage ----------------
  logic [NUM_BANDS-1:0][DATA_W-1:0] cur_q, prv_q, first_q;

  subband_band_store #(
    .DATA_W (DATA_W),
    .NBANDS (NUM_BANDS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_band  (in_tag),
    .wr_first (cur_first),
    .wr_data  (in_data),
    .cur_q    (cur_q),
    .prv_q    (prv_q),
    .first_q  (first_q)
  );

  // ---------------- operand selection ----------------
  logic [1:0] lo_band, hi_band;
  logic signed [DATA_W-1:0] op_a, op_b, op_c, op_d;

  assign lo_band = emit_seg ? BAND_HL : BAND_LL;
  assign hi_band = emit_seg ? BAND_HH : BAND_LH;

  always_comb begin
    if (wrap_busy) begin
      op_a = cur_q[lo_band];
      op_b = first_q[lo_band];
      op_c = cur_q[hi_band];
      op_d = first_q[hi_band];
    end else begin
      op_a = prv_q[lo_band];
      op_b = cur_q[lo_band];
      op_c = cur_q[hi_band];
      op_d = in_data;
    end
  end

  // ---------------- filtering ----------------
  logic signed [DATA_W-1:0] k_near [2];
  logic signed [DATA_W-1:0] k_far  [2];
  logic signed [ACC_W-1:0]  k_even [2];
  logic signed [ACC_W-1:0]  k_odd  [2];

  assign k_near[0] = op_a;
  assign k_far[0]  = op_b;
  assign k_near[1] = op_c;
  assign k_far[1]  = op_d;

  for (genvar k = 0; k < 2; k++) begin : g_kernel
    subband_tap_kernel #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .HIGH   (k == 1)
    ) u_kernel (
      .x_near (k_near[k]),
      .x_far  (k_far[k]),
      .y_even (k_even[k]),
      .y_odd  (k_odd[k])
    );
  end

  logic signed [ACC_W-1:0]  sum_even, sum_odd;
  logic signed [DATA_W-1:0] rnd_even, rnd_odd;

  assign sum_even = k_even[0] + k_even[1];
  assign sum_odd  = k_odd[0]  + k_odd[1];

  subband_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_rnd_even (
    .sum_in  (sum_even),
    .val_out (rnd_even)
  );
  subband_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_rnd_odd (
    .sum_in  (sum_odd),
    .val_out (rnd_odd)
  );

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_tag     <= 1'b0;
      out_even    <= '0;
      out_odd     <= '0;
    end else if (emit) begin
      out_valid_q <= 1'b1;
      out_tag     <= emit_seg;
      out_even    <= rnd_even;
      out_odd     <= rnd_odd;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
endmodule

// File: rtl/subband_hsynth_chk.sv
module subband_hsynth_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_tag,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_tag,
  input logic [9:0] out_even,
  input logic [9:0] out_odd,
  input logic       wrap_busy,
  input logic       emit_run,
  input logic       cur_first
);
  logic [1:0] want_tag;
  logic       last_tag, seen_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_tag <= 2'd0;
      last_tag <= 1'b1;
      seen_out <= 1'b0;
    end else begin
      if (in_valid && in_ready) want_tag <= want_tag + 2'd1;
      if (out_valid && out_ready) begin
        last_tag <= out_tag;
        seen_out <= 1'b1;
      end
    end
  end

  // R3
  band_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (in_tag == want_tag));

  // R3
  tag_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && seen_out) |-> (out_tag != last_tag));

  // R4
  first_group_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tag[0] && cur_first) |=> !out_valid);

  // R5
  wrap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_busy |-> !in_ready);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_tag) && $stable(out_even) && $stable(out_odd)));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R4
  no_emit_in_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_busy |-> !emit_run);
endmodule

bind subband_hsynth subband_hsynth_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tag   (out_tag),
  .out_even  (out_even),
  .out_odd   (out_odd),
  .wrap_busy (wrap_busy),
  .emit_run  (emit_run),
  .cur_first (cur_first)
);

// File: tb/test_subband_hsynth.sv
module test_subband_hsynth;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_tag = 2'd0;
  logic in_line_start = 1'b0;
  logic in_line_end = 1'b0;
  logic signed [9:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_tag;
  logic signed [9:0] out_even, out_odd;

  always #10 clk = ~clk;

  subband_hsynth i_subband_hsynth (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_line_start(in_line_start), .in_line_end(in_line_end), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_even(out_even), .out_odd(out_odd)
  );

  typedef struct {
    int    tag;
    int    ev;
    int    od;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // rounding half up by 8, then clamp to the 10-bit signed range (R6, R7)
  function automatic int scale_clip(input int s);
    int t, q;
    t = s + 4;
    if (t >= 0) q = t / 8;
    else        q = -((-t + 7) / 8);
    if (q > 511)  q = 511;
    if (q < -512) q = -512;
    return q;
  endfunction

  function automatic int pick(input int mode, input int band, input int i);
    case (mode)
      0: return (band == 0) ? (i * 53 - 97) : 0;            // R1
      1: return (band == 1) ? (40 - i * 71) : 0;            // R2
      2: return ((band * 37 + i * 29 + 5) % 61) - 30;       // R3, R6
      3: return ((band + i) % 2 == 0) ? 511 : -512;         // R7
      default: return ((band * 131 + i * 77) % 1024) - 512;
    endcase
  endfunction

  task automatic send_beat(input int tag, input int val, input bit ls, input bit le);
    bit done;
    @(negedge clk);
    in_valid      = 1'b1;
    in_tag        = 2'(tag);
    in_data       = 10'(val);
    in_line_start = ls;
    in_line_end   = le;
    done = 0;
    while (!done) begin
      #8;
      done = in_ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    in_valid      = 1'b0;
    in_line_start = 1'b0;
    in_line_end   = 1'b0;
  endtask

  task automatic run_line(input int n, input int mode, input string req);
    int v[4][8];
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 4; b++) v[b][i] = pick(mode, b, i);
    for (int i = 0; i < n; i++) begin
      int j;
      exp_t e;
      j = (i + 1) % n;   // last index wraps to the first coefficient (R5)
      for (int seg = 0; seg < 2; seg++) begin
        int a, b2, c, d;
        a  = v[2*seg][i];
        b2 = v[2*seg][j];
        c  = v[2*seg+1][i];
        d  = v[2*seg+1][j];
        e.tag = seg;
        e.ev  = scale_clip(6*a - b2 + c - 6*d);
        e.od  = scale_clip(3*a + 2*b2 + 2*c + 3*d);
        e.req = (i == n - 1) ? {req, "/R5"} : req;
        sb_q.push_back(e);
      end
    end
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 4; b++)
        send_beat(b, v[b][i], (b == 0) && (i == 0), (b == 0) && (i == n - 1));
  endtask

  // downstream ready pattern
  int rcnt = 0;
  always @(posedge clk) begin
    #2;
    rcnt++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (rcnt % 3) != 0;
      default: out_ready = (rcnt % 4) == 0;
    endcase
  end

  // monitor / scoreboard
  bit was_stalled = 0;
  int hold_tag, hold_ev, hold_od;
  always @(negedge clk) begin
    #8;
    if (rst_n && !finished) begin
      if (was_stalled) begin
        check(out_valid == 1'b1, "R8", "valid held", int'(out_valid), 1);
        check(out_tag == hold_tag[0] && int'(out_even) == hold_ev && int'(out_odd) == hold_od,
              "R8", "data held", int'(out_even), hold_ev);
      end
      was_stalled = out_valid && !out_ready;
      hold_tag = int'(out_tag);
      hold_ev  = int'(out_even);
      hold_od  = int'(out_odd);
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(0, "R4", "unexpected output", int'(out_even), 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(out_tag) == e.tag, e.req, "tag", int'(out_tag), e.tag);
          check(int'(out_even) == e.ev, e.req, "even", int'(out_even), e.ev);
          check(int'(out_odd) == e.od, e.req, "odd", int'(out_odd), e.od);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic drain();
    int guard = 0;
    while (sb_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    check(sb_q.size() == 0, "R4", "pending results", sb_q.size(), 0);
  endtask

  initial begin
    #8;
    check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #8;
    check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

    rdy_mode = 0;
    run_line(5, 0, "R1");
    run_line(4, 1, "R2");
    drain();
    rdy_mode = 1;
    run_line(6, 2, "R3/R6");
    run_line(3, 3, "R7");
    drain();
    rdy_mode = 0;
    run_line(1, 4, "R10");
    drain();
    rdy_mode = 2;
    run_line(2, 4, "R8");
    run_line(1, 2, "R10");
    run_line(7, 4, "R8");
    drain();
    finish_run();
  end
endmodule